// File: doc/BRIEF.md
# Shared-Term Four-Point Integer Transform

This block turns a vector of four signed samples into four signed results through a fixed integer matrix whose entries are only plus or minus one and plus or minus two. It uses no multiplier. A first rank of four adders forms pairwise sums and differences of the inputs. A second rank of four adders combines those partial terms, and two of its operands are doubled with a one-bit left shift. Because the four partial terms are shared between the outputs, the whole transform costs eight add/subtract operations and two shifts, where evaluating each row directly would take twelve additions and four shifts.

Each adder drives a register, so the block is a two-stage pipeline. It takes a fresh input vector on every clock and returns the matching results two clocks later. A valid flag moves through the pipeline next to the data. The result width grows by three bits over the input width, which holds every possible result exactly. Software or upstream logic only has to present an input vector with the valid flag and pick up the results when the flag comes out.

Top module: `xform4_shared`

## Requirements
- R1: When `out_valid` is high, `y0` equals x0 + x1 + x2 + x3 of the vector that was presented with `in_valid` high two clocks before.
- R2: When `out_valid` is high, `y1` equals 2·x0 + x1 − x2 − 2·x3 of that same earlier vector.
- R3: When `out_valid` is high, `y2` equals x0 − x1 − x2 + x3 of that same earlier vector.
- R4: When `out_valid` is high, `y3` equals x0 − 2·x1 + 2·x2 − x3 of that same earlier vector.
- R5: Latency is exactly two clocks. A vector sampled at rising edge n produces `out_valid` and its results right after rising edge n+1.
- R6: A new vector is accepted on every clock. Back-to-back vectors come out back-to-back, in order, with no gap.
- R7: Inputs are W-bit two's complement and outputs are (W+3)-bit two's complement. Every input combination, the most negative and most positive values included, gives the exact result without wrap-around.
- R8: A synchronous active-high `rst` clears the valid pipeline. `out_valid` is low on the clock after any reset edge, and any vector already in flight when reset is sampled is dropped.
- R9: A clock with `in_valid` low gives `out_valid` low two clocks later, so gaps in the input stream show up as identical gaps in the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks x0..x3 as a vector to transform |
| x0 | input | W | Input sample 0, signed |
| x1 | input | W | Input sample 1, signed |
| x2 | input | W | Input sample 2, signed |
| x3 | input | W | Input sample 3, signed |
| out_valid | output | 1 | Marks y0..y3 as a finished result |
| y0 | output | W+3 | Result row 0, signed |
| y1 | output | W+3 | Result row 1, signed |
| y2 | output | W+3 | Result row 2, signed |
| y3 | output | W+3 | Result row 3, signed |

## Verification
A wrong partial term in the first rank always damages at least two outputs, because each term feeds two rows. The error shows on the second clock after the faulty vector enters and stays confined to that one result slot. A wrong shift or a wrong width shows up only near the extreme input values, so the bench sweeps every combination of a narrow input width and checks all four rows at each step. A fault in the valid chain shows within two clocks as a missing, extra or misplaced `out_valid`, both in a dense stream and in a stream with gaps.

// File: rtl/xform_pkg.sv
package xform_pkg;

    localparam int LANES      = 4;
    localparam int MID_GROW   = 1;
    localparam int OUT_GROW   = 3;
    localparam int PIPE_DEPTH = 2;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // One adder: a (+|-) (b shifted left by shl)
    typedef struct packed {
        logic [1:0] a;
        logic [1:0] b;
        op_e        op;
        logic       shl;
    } term_t;

    // First rank: shared pairwise terms
    function automatic term_t mid_term(input int k);
        term_t t;
        case (k)
            0:       t = '{a: 2'd0, b: 2'd3, op: OP_ADD, shl: 1'b0};
            1:       t = '{a: 2'd1, b: 2'd2, op: OP_SUB, shl: 1'b0};
            2:       t = '{a: 2'd1, b: 2'd2, op: OP_ADD, shl: 1'b0};
            default: t = '{a: 2'd0, b: 2'd3, op: OP_SUB, shl: 1'b0};
        endcase
        return t;
    endfunction

    // Second rank: rows built from the shared terms
    function automatic term_t out_term(input int k);
        term_t t;
        case (k)
            0:       t = '{a: 2'd0, b: 2'd2, op: OP_ADD, shl: 1'b0};
            1:       t = '{a: 2'd1, b: 2'd3, op: OP_ADD, shl: 1'b1};
            2:       t = '{a: 2'd0, b: 2'd2, op: OP_SUB, shl: 1'b0};
            default: t = '{a: 2'd3, b: 2'd1, op: OP_SUB, shl: 1'b1};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/xform_lane.sv
module xform_lane #(
    parameter int             IW  = 8,
    parameter int             OW  = IW + 1,
    parameter xform_pkg::op_e OP  = xform_pkg::OP_ADD,
    parameter bit             SHL = 1'b0
) (
    input  logic                 clk,
    input  logic signed [IW-1:0] a,
    input  logic signed [IW-1:0] b,
    output logic signed [OW-1:0] q
);
    logic signed [OW-1:0] a_x;
    logic signed [OW-1:0] b_x;
    logic signed [OW-1:0] res;

    always_comb begin
        a_x = OW'(a);
        b_x = OW'(b);
        if (SHL) begin
            b_x = b_x <<< 1;
        end
        if (OP == xform_pkg::OP_SUB) begin
            res = a_x - b_x;
        end else begin
            res = a_x + b_x;
        end
    end

    always_ff @(posedge clk) begin
        q <= res;
    end
endmodule

// File: rtl/xform_stage.sv
module xform_stage #(
    parameter int IW     = 8,
    parameter int OW     = IW + 1,
    parameter bit SECOND = 1'b0
) (
    input  logic                 clk,
    input  logic signed [IW-1:0] v [xform_pkg::LANES],
    output logic signed [OW-1:0] q [xform_pkg::LANES]
);
    import xform_pkg::*;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam term_t T = SECOND ? out_term(k) : mid_term(k);
        xform_lane #(
            .IW (IW),
            .OW (OW),
            .OP (T.op),
            .SHL(T.shl)
        ) u_lane (
            .clk(clk),
            .a  (v[T.a]),
            .b  (v[T.b]),
            .q  (q[k])
        );
    end
endmodule

// File: rtl/xform_vpipe.sv
module xform_vpipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign dout = sr[DEPTH-1];
endmodule

// File: rtl/xform4_shared.sv
module xform4_shared
    import xform_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [W-1:0]   x0,
    input  logic signed [W-1:0]   x1,
    input  logic signed [W-1:0]   x2,
    input  logic signed [W-1:0]   x3,
    output logic                  out_valid,
    output logic signed [W+2:0]   y0,
    output logic signed [W+2:0]   y1,
    output logic signed [W+2:0]   y2,
    output logic signed [W+2:0]   y3
);
    localparam int MW = W + MID_GROW;
    localparam int OW = W + OUT_GROW;

    logic signed [W-1:0]  x_vec [LANES];
    logic signed [MW-1:0] d_vec [LANES];
    logic signed [OW-1:0] y_vec [LANES];

    always_comb begin
        x_vec[0] = x0;
        x_vec[1] = x1;
        x_vec[2] = x2;
        x_vec[3] = x3;
    end

    xform_stage #(
        .IW    (W),
        .OW    (MW),
        .SECOND(1'b0)
    ) u_mid (
        .clk(clk),
        .v  (x_vec),
        .q  (d_vec)
    );

    xform_stage #(
        .IW    (MW),
        .OW    (OW),
        .SECOND(1'b1)
    ) u_out (
        .clk(clk),
        .v  (d_vec),
        .q  (y_vec)
    );

    xform_vpipe #(
        .DEPTH(PIPE_DEPTH)
    ) u_vld (
        .clk (clk),
        .rst (rst),
        .din (in_valid),
        .dout(out_valid)
    );

    assign y0 = y_vec[0];
    assign y1 = y_vec[1];
    assign y2 = y_vec[2];
    assign y3 = y_vec[3];
endmodule

// File: rtl/xform4_shared_chk.sv
module xform4_shared_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic signed [W-1:0] x0,
    input logic signed [W-1:0] x1,
    input logic signed [W-1:0] x2,
    input logic signed [W-1:0] x3,
    input logic                out_valid,
    input logic signed [W+2:0] y0,
    input logic signed [W+2:0] y1,
    input logic signed [W+2:0] y2,
    input logic signed [W+2:0] y3
);
    localparam int OW = W + 3;

    logic [1:0] run_cnt;
    logic       armed;
    logic signed [OW-1:0] a0, a1, a2, a3;
    logic signed [OW-1:0] e0, e1, e2, e3;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 2'd0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    assign armed = (run_cnt >= 2'd2);

    // Direct row evaluation, no shared terms
    always_comb begin
        a0 = OW'(x0);
        a1 = OW'(x1);
        a2 = OW'(x2);
        a3 = OW'(x3);
        e0 = a0 + a1 + a2 + a3;
        e1 = 2 * a0 + a1 - a2 - 2 * a3;
        e2 = a0 - a1 - a2 + a3;
        e3 = a0 - 2 * a1 + 2 * a2 - a3;
    end

    assert_row0_R1: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (y0 == $past(e0, 2)));

    assert_row1_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (y1 == $past(e1, 2)));

    assert_row2_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (y2 == $past(e2, 2)));

    assert_row3_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && out_valid) |-> (y3 == $past(e3, 2)));

    // R5, R6, R9: valid follows in_valid by exactly two clocks
    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid, 2)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind xform4_shared xform4_shared_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .x0       (x0),
    .x1       (x1),
    .x2       (x2),
    .x3       (x3),
    .out_valid(out_valid),
    .y0       (y0),
    .y1       (y1),
    .y2       (y2),
    .y3       (y3)
);

// File: tb/tb_xform4_shared.sv
module tb_xform4_shared;
    localparam int  W        = 3;
    localparam time CLK_HALF = 5ns;
    localparam int  SPAN     = 1 << W;
    localparam int  ALL      = SPAN * SPAN * SPAN * SPAN;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
    logic                out_valid;
    logic signed [W+2:0] y0, y1, y2, y3;

    int checks = 0;
    int errors = 0;

    // history: index 1 = last step, index 2 = two steps ago
    logic h_v [1:2];
    int   h_x [1:2][4];

    always #CLK_HALF clk = ~clk;

    xform4_shared #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3),
        .out_valid(out_valid),
        .y0(y0), .y1(y1), .y2(y2), .y3(y3)
    );

    function automatic int sx(input int raw);
        int v = raw & (SPAN - 1);
        if (v >= SPAN / 2) v -= SPAN;
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: compare outputs with vector driven two steps ago, then drive
    task automatic step(input logic r, input logic v, input int a, input int b,
                        input int c, input int d, input string vtag);
        int e0, e1, e2, e3;
        @(negedge clk);
        chk(vtag, int'(out_valid), int'(h_v[2]));
        if (h_v[2]) begin
            e0 = h_x[2][0] + h_x[2][1] + h_x[2][2] + h_x[2][3];
            e1 = 2*h_x[2][0] + h_x[2][1] - h_x[2][2] - 2*h_x[2][3];
            e2 = h_x[2][0] - h_x[2][1] - h_x[2][2] + h_x[2][3];
            e3 = h_x[2][0] - 2*h_x[2][1] + 2*h_x[2][2] - h_x[2][3];
            chk("R1/R7 y0", int'(y0), e0);
            chk("R2/R7 y1", int'(y1), e1);
            chk("R3/R7 y2", int'(y2), e2);
            chk("R4/R7 y3", int'(y3), e3);
        end
        h_v[2] = r ? 1'b0 : h_v[1];
        h_x[2] = h_x[1];
        h_v[1] = v && !r;
        h_x[1] = '{a, b, c, d};
        rst      = r;
        in_valid = v;
        x0 = W'(a); x1 = W'(b); x2 = W'(c); x3 = W'(d);
    endtask

    initial begin
        h_v[1] = 1'b0; h_v[2] = 1'b0;
        h_x[1] = '{0, 0, 0, 0}; h_x[2] = '{0, 0, 0, 0};
        repeat (3) @(negedge clk);
        chk("R8 reset state", int'(out_valid), 0);

        // R5: single isolated vector
        step(1'b0, 1'b1, 1, -2, 3, -4, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, 0, 0, "R5");

        // R6/R7: every input combination, back to back
        for (int i = 0; i < ALL; i++) begin
            step(1'b0, 1'b1, sx(i), sx(i >> W), sx(i >> (2*W)), sx(i >> (3*W)), "R6");
        end

        // R9: same sweep with gaps in the stream
        for (int i = 0; i < ALL; i++) begin
            step(1'b0, (i % 3) != 1, sx(i * 7), sx(i >> W), sx(i >> (2*W)), sx(i >> (3*W)), "R9");
        end

        // R8: reset while vectors are in flight drops them
        step(1'b0, 1'b1, 3, 3, 3, 3, "R6");
        step(1'b0, 1'b1, -4, -4, -4, -4, "R6");
        step(1'b1, 1'b1, 2, 2, 2, 2, "R8");
        step(1'b0, 1'b0, 0, 0, 0, 0, "R8");
        step(1'b0, 1'b0, 0, 0, 0, 0, "R8");
        step(1'b0, 1'b1, -4, 3, -4, 3, "R8");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, 0, 0, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule